// File: doc/BRIEF.md
# Preconditioning Arithmetic-Logic Unit

This block is a purely combinational 16-bit arithmetic-logic unit with two operands, `a_in` and `b_in`, and six independent control bits. There is no opcode and no decoder. Each operand goes through a fixed pipeline of combinational steps. It can first be cleared to zero, and the value from that step can then be bitwise inverted. A select bit then chooses either the two's-complement sum or the bitwise AND of the two conditioned operands. A final control bit can invert that intermediate result.

Different settings of the six bits produce many functions. These include the constants 0, 1 and -1, either operand unchanged, Boolean NOT, arithmetic negation, increment, decrement, add, subtract in both directions, AND and OR. Two status outputs report whether the result is zero and whether it is negative.

The block is used as the compute core of a small datapath. The surrounding logic drives the control bits straight from an instruction field.

Top module: `precond_alu`

## Requirements
- R1: When `clr_a` is 1, operand A is replaced by zero before any other step acts on it.
- R2: When `inv_a` is 1, the value from the clear step for A is bitwise inverted with Boolean NOT, so an inverted cleared operand is 0xFFFF.
- R3: `clr_b` and `inv_b` act on operand B in the same way and in the same order as `clr_a` and `inv_a` act on A.
- R4: When `sel_add` is 1, the intermediate result is the sum of the conditioned operands modulo 2^16, with the carry out of bit 15 dropped. For example, 0xFFFF plus 0xFFFF gives 0xFFFE.
- R5: When `sel_add` is 0, the intermediate result is the bitwise AND of the conditioned operands.
- R6: When `inv_out` is 1, `result` is the bitwise inverse of the intermediate result; otherwise `result` equals the intermediate result.
- R7: With all six control bits at 1, `result` is 0x0001 for any operands.
- R8: `is_zero` is 1 exactly when all 16 bits of `result` are 0.
- R9: `is_neg` equals bit 15 of `result`.
- R10: The control word {clr_a, inv_a, clr_b, inv_b, sel_add, inv_out} selects a function as follows:
  - 101010 gives 0; 111111 gives 1; 111010 gives -1.
  - 001100 gives A; 110000 gives B.
  - 001101 gives ~A; 110001 gives ~B.
  - 001111 gives -A; 110011 gives -B.
  - 011111 gives A+1; 110111 gives B+1.
  - 001110 gives A-1; 110010 gives B-1.
  - 000010 gives A+B; 010011 gives A-B; 000111 gives B-A.
  - 000000 gives A&B; 010101 gives A|B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 16 | Operand A |
| b_in | input | 16 | Operand B |
| clr_a | input | 1 | Clear operand A to zero |
| inv_a | input | 1 | Invert A after the clear step |
| clr_b | input | 1 | Clear operand B to zero |
| inv_b | input | 1 | Invert B after the clear step |
| sel_add | input | 1 | 1 selects the sum, 0 selects the AND |
| inv_out | input | 1 | Invert the intermediate result |
| result | output | 16 | Final result |
| is_zero | output | 1 | Result is zero |
| is_neg | output | 1 | Bit 15 of the result |

## Verification
The block holds no state, so any internal fault shows up on `result` or the flags as soon as the inputs settle, in the same cycle the stimulus is applied. Some faults affect only particular operand patterns. Two examples are a clear and an invert applied in the wrong order, which shows only when both bits are set, and a carry leaking past bit 15, which shows only when the sum overflows. The bench therefore drives every one of the 64 control words with random operands and adds directed overflow and all-ones vectors.

// File: rtl/precond_alu.sv
module precond_alu #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             clr_a,
  input  logic             inv_a,
  input  logic             clr_b,
  input  logic             inv_b,
  input  logic             sel_add,
  input  logic             inv_out,
  output logic [WIDTH-1:0] result,
  output logic             is_zero,
  output logic             is_neg
);

  logic [WIDTH-1:0] a_clr, a_cond, b_clr, b_cond, core;

  assign a_clr  = clr_a ? '0 : a_in;
  assign a_cond = inv_a ? ~a_clr : a_clr;
  assign b_clr  = clr_b ? '0 : b_in;
  assign b_cond = inv_b ? ~b_clr : b_clr;

  assign core    = sel_add ? a_cond + b_cond : a_cond & b_cond;
  assign result  = inv_out ? ~core : core;
  assign is_zero = ~|result;
  assign is_neg  = result[WIDTH-1];

endmodule

// File: rtl/precond_alu_chk.sv
module precond_alu_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic             clr_a,
  input logic             inv_a,
  input logic             clr_b,
  input logic             inv_b,
  input logic             sel_add,
  input logic             inv_out,
  input logic [WIDTH-1:0] result,
  input logic             is_zero,
  input logic             is_neg
);

  logic [5:0] ctl;
  assign ctl = {clr_a, inv_a, clr_b, inv_b, sel_add, inv_out};

  always_comb begin
    if (ctl == 6'b111111)
      assert_all_set_R7: assert (result == WIDTH'(1));
    if (ctl == 6'b101010)
      assert_cleared_sum_R1: assert (result == '0);
    if (ctl == 6'b000000)
      assert_plain_and_R5: assert (result == (a_in & b_in));
    if (ctl == 6'b000010)
      assert_plain_sum_R4: assert (result == WIDTH'(a_in + b_in));
    if (ctl == 6'b001101)
      assert_not_a_R6: assert (result == ~a_in);
    if (is_zero)
      assert_zero_not_neg_R9: assert (!is_neg);
  end

endmodule

bind precond_alu precond_alu_chk #(.WIDTH(WIDTH)) chk_i (
  .a_in(a_in), .b_in(b_in), .clr_a(clr_a), .inv_a(inv_a),
  .clr_b(clr_b), .inv_b(inv_b), .sel_add(sel_add), .inv_out(inv_out),
  .result(result), .is_zero(is_zero), .is_neg(is_neg)
);

// File: tb/precond_alu_tb_top.sv
module precond_alu_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] a, b, res;
  logic [5:0]  ctl;
  logic        zf, nf;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  precond_alu dut_i (
    .a_in(a), .b_in(b),
    .clr_a(ctl[5]), .inv_a(ctl[4]), .clr_b(ctl[3]), .inv_b(ctl[2]),
    .sel_add(ctl[1]), .inv_out(ctl[0]),
    .result(res), .is_zero(zf), .is_neg(nf)
  );

  // Expected value of a named function, computed arithmetically.
  function automatic logic [15:0] named_fn(logic [5:0] c, int x, int y);
    int r;
    case (c)
      6'b101010: r = 0;
      6'b111111: r = 1;
      6'b111010: r = -1;
      6'b001100: r = x;
      6'b110000: r = y;
      6'b001101: r = -x - 1;
      6'b110001: r = -y - 1;
      6'b001111: r = -x;
      6'b110011: r = -y;
      6'b011111: r = x + 1;
      6'b110111: r = y + 1;
      6'b001110: r = x - 1;
      6'b110010: r = y - 1;
      6'b000010: r = x + y;
      6'b010011: r = x - y;
      6'b000111: r = y - x;
      6'b000000: r = x & y;
      default:   r = x | y;
    endcase
    return 16'(r);
  endfunction

  // General model over all 64 words, written with integer arithmetic.
  function automatic logic [15:0] gen_fn(logic [5:0] c, int x, int y);
    int p, q, r;
    p = c[5] ? 0 : x;
    if (c[4]) p = 65535 - p;
    q = c[3] ? 0 : y;
    if (c[2]) q = 65535 - q;
    r = c[1] ? (p + q) % 65536 : (p & q);
    if (c[0]) r = 65535 - r;
    return 16'(r);
  endfunction

  task automatic apply(logic [5:0] c, logic [15:0] x, logic [15:0] y);
    @(posedge clk);
    ctl = c; a = x; b = y;
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s ctl=%b a=%h b=%h got=%h exp=%h", req, ctl, a, b, got, exp);
    end
  endtask

  task automatic chk_flags();
    chk("R8", {15'd0, zf}, {15'd0, res == 16'd0});
    chk("R9", {15'd0, nf}, {15'd0, res[15]});
  endtask

  localparam logic [5:0] FN [18] = '{
    6'b101010, 6'b111111, 6'b111010, 6'b001100, 6'b110000, 6'b001101,
    6'b110001, 6'b001111, 6'b110011, 6'b011111, 6'b110111, 6'b001110,
    6'b110010, 6'b000010, 6'b010011, 6'b000111, 6'b000000, 6'b010101};

  initial begin
    ctl = '0; a = '0; b = '0;
    @(negedge clk);
    chk("R5 idle", res, 16'h0000);
    chk("R8 idle", {15'd0, zf}, 16'd1);
    // R1: clear A, pass A+B -> B
    apply(6'b100010, 16'h1234, 16'h0005); chk("R1", res, 16'h0005);
    // R2: clear then invert A, AND with B -> B
    apply(6'b110000, 16'h1234, 16'hBEEF); chk("R2", res, 16'hBEEF);
    apply(6'b010000, 16'h1234, 16'hFFFF); chk("R2", res, 16'hEDCB);
    // R3: same order on B
    apply(6'b001100, 16'hCAFE, 16'h7777); chk("R3", res, 16'hCAFE);
    apply(6'b000100, 16'hFFFF, 16'h00F0); chk("R3", res, 16'hFF0F);
    // R4: carry dropped
    apply(6'b000010, 16'hFFFF, 16'hFFFF); chk("R4", res, 16'hFFFE);
    apply(6'b000010, 16'h8000, 16'h8000); chk("R4", res, 16'h0000);
    chk_flags();
    // R5: AND
    apply(6'b000000, 16'hF0F0, 16'h3C3C); chk("R5", res, 16'h3030);
    // R6: output invert
    apply(6'b000001, 16'hF0F0, 16'h3C3C); chk("R6", res, 16'hCFCF);
    // R7: all set
    for (int i = 0; i < 20; i++) begin
      apply(6'b111111, 16'($urandom), 16'($urandom)); chk("R7", res, 16'h0001);
    end
    // R9: negative
    apply(6'b111010, 16'h0, 16'h0); chk("R9", {15'd0, nf}, 16'd1);
    // R10: named functions
    for (int k = 0; k < 18; k++)
      for (int i = 0; i < 40; i++) begin
        logic [15:0] x, y;
        x = 16'($urandom); y = 16'($urandom);
        if (i == 0) begin x = 16'h0; y = 16'hFFFF; end
        if (i == 1) begin x = 16'h7FFF; y = 16'h8000; end
        apply(FN[k], x, y);
        chk("R10", res, named_fn(FN[k], int'(x), int'(y)));
        chk_flags();
      end
    // R6: all 64 words against the general model
    for (int c = 0; c < 64; c++)
      for (int i = 0; i < 20; i++) begin
        logic [15:0] x, y;
        x = 16'($urandom); y = 16'($urandom);
        apply(6'(c), x, y);
        chk("R6 sweep", res, gen_fn(6'(c), int'(x), int'(y)));
        chk_flags();
      end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule